// File: doc/BRIEF.md
# Clocked Pseudo-Static RAM Device Model

This block stands in for a 16-bit pseudo-static RAM on the memory side of a controller testbench. The controls look like an asynchronous SRAM: an active-low chip select, a high-active power control input, active-low write and output enables, and one active-low enable per byte lane. Every control is sampled on a simulation clock edge. The bidirectional data pins are split into a data-in bus, a data-out bus and one output-drive flag per byte lane. A flag of 0 stands for a high-impedance lane.

The model decodes the access mode and masks bytes on reads and on writes. It also tracks the power states: the settling wait after power-on, the active and standby states, and deep power down. Deep power down destroys the stored contents. The model shows this by filling every word with a poison pattern, so a controller that reads stale data after wake-up gets a value it can recognise. The full device has a 20-bit word address. The model keeps that address width but stores only `2**DEPTH_W` words and ignores the upper address bits. The settling wait is counted as `CLK_MHZ * WAIT_US` clock edges.

The reset input is asynchronous and active low, and its release is synchronised through two flops. The first edge with functional behaviour is therefore the third rising edge after `rst_n` goes high.

Top module: `psram_model`

## Requirements
- R1: After reset release, the model ignores all accesses for `CLK_MHZ*WAIT_US` functional edges. During that time `dout_en` stays 00 and writes do not change the array.
- R2: A write stores `din[7:0]` when `lb_n` is low and `din[15:8]` when `ub_n` is low, at the word selected by `addr`. A lane whose enable is high keeps its old byte. A write needs `cs1_n` low, `we_n` low and at least one lane enable low.
- R3: A write commits on the first sampled edge of an overlap window. Further edges on which the overlap still holds do not write, even if `din` or `addr` change.
- R4: A read is taken on an edge where `cs1_n`=0, `cs2`=1, `we_n`=1 and `oe_n`=0. After that edge, `dout_en[0]` and `dout[7:0]` show the lower byte when `lb_n` is low, and `dout_en[1]` and `dout[15:8]` show the upper byte when `ub_n` is low. A lane that is not driven reads as 0 with its flag at 0.
- R5: When `cs1_n` is high, or when both lane enables are high, or when `oe_n` is high with `we_n` high, `dout_en` is 00 after the edge.
- R6: After any edge sampled with `we_n` low, `dout_en` is 00, including when `oe_n` is low.
- R7: An edge with `cs2` low enters deep power down. Every word then becomes `POISON` (default 16'hDEAD), and no access is taken while `cs2` stays low.
- R8: The first edge with `cs2` high after deep power down leaves that state. Accesses are then ignored for a further `CLK_MHZ*WAIT_US` edges, after which the model works normally.
- R9: Only `addr[DEPTH_W-1:0]` selects a word. Addresses that differ only in the upper bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Active-low chip select |
| cs2 | input | 1 | Power control; low requests deep power down |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| lb_n | input | 1 | Active-low lower byte lane enable (bits 7:0) |
| ub_n | input | 1 | Active-low upper byte lane enable (bits 15:8) |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data; 0 on lanes that are not driven |
| dout_en | output | 2 | Lane drive flags; bit 0 lower, bit 1 upper |

## Verification
The bench targets the edge counts around the settling waits, a write overlap held over several edges while its data changes, single-lane writes and reads, and the case where `we_n` falls after a read has already started. A counter that is off by one would drive data one edge early or swallow the first real access. Writing on every edge of an overlap would leave the last data in place of the first. A missing lane mask would corrupt the other byte, and a read path left open during writes would raise `dout_en`. After deep power down the bench reads back words that were written before entry and words written during the wake-up wait. Both must return the poison pattern; a model that keeps old contents, or takes writes too early, fails those reads.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef logic [LANES-1:0] lane_t;

  typedef enum logic [1:0] {
    PS_WAKE = 2'd0,
    PS_STBY = 2'd1,
    PS_ACT  = 2'd2,
    PS_DPD  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
  import psram_pkg::*;
#(
  parameter int WAIT_CYC = 40000,
  parameter int CNT_W    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs2_i,
  input  logic sel_i,
  output logic ready_o,
  output logic poison_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

  pwr_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!cs2_i) begin
      st_d = PS_DPD;
    end else begin
      case (st_q)
        PS_DPD: begin
          st_d   = PS_WAKE;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
        PS_WAKE: begin
          if (cnt_q == CNT_LAST) begin
            st_d = sel_i ? PS_ACT : PS_STBY;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: st_d = sel_i ? PS_ACT : PS_STBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_WAKE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready_o  = (st_q == PS_STBY) || (st_q == PS_ACT);
  assign poison_o = !cs2_i && (st_q != PS_DPD);

  // R7: cs2 low always lands in deep power down
  assert_dpd_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs2_i |=> st_q == PS_DPD);

  // R8: leaving deep power down restarts the settling count from zero
  assert_dpd_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_DPD) && cs2_i |=> (st_q == PS_WAKE) && (cnt_q == '0));
endmodule

// File: rtl/psram_mode_dec.sv
module psram_mode_dec
  import psram_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ready_i,
  input  logic  cs1_n_i,
  input  logic  cs2_i,
  input  logic  we_n_i,
  input  logic  oe_n_i,
  input  lane_t lane_n_i,
  output logic  sel_o,
  output lane_t wr_lanes_o,
  output lane_t rd_lanes_o
);
  lane_t lane_on;
  logic  chip_on;
  logic  overlap;
  logic  overlap_q;
  logic  access_ok;

  assign lane_on   = ~lane_n_i;
  assign chip_on   = !cs1_n_i && (|lane_on);
  assign overlap   = chip_on && !we_n_i;
  assign access_ok = ready_i && cs2_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overlap_q <= 1'b0;
    end else begin
      overlap_q <= overlap;
    end
  end

  assign wr_lanes_o = (access_ok && overlap && !overlap_q) ? lane_on : '0;
  assign rd_lanes_o = (access_ok && chip_on && we_n_i && !oe_n_i) ? lane_on : '0;
  assign sel_o      = chip_on;

  // R3: an overlap that persists past its commit edge writes nothing more
  assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_lanes_o) && overlap |=> wr_lanes_o == '0);
endmodule

// File: rtl/psram_array.sv
module psram_array
  import psram_pkg::*;
#(
  parameter int                DEPTH_W = 6,
  parameter logic [DATA_W-1:0] POISON  = 16'hDEAD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               poison_i,
  input  lane_t              wr_lanes_i,
  input  lane_t              rd_lanes_i,
  input  logic [DEPTH_W-1:0] idx_i,
  input  logic [DATA_W-1:0]  din_i,
  output logic [DATA_W-1:0]  dout_o,
  output lane_t              dout_en_o
);
  localparam int DEPTH = 1 << DEPTH_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LANE_W-1:0] LANE_POISON = POISON[g*LANE_W +: LANE_W];

    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] wr_byte;
    logic [LANE_W-1:0] rd_q;
    logic              en_q;

    assign wr_byte = din_i[g*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (poison_i) begin
        for (int w = 0; w < DEPTH; w++) begin
          bank[w] <= LANE_POISON;
        end
      end else if (wr_lanes_i[g]) begin
        bank[idx_i] <= wr_byte;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q <= '0;
        en_q <= 1'b0;
      end else begin
        en_q <= rd_lanes_i[g];
        rd_q <= rd_lanes_i[g] ? bank[idx_i] : '0;
      end
    end

    assign dout_o[g*LANE_W +: LANE_W] = rd_q;
    assign dout_en_o[g]               = en_q;

    // R7: right after entry every word of this lane holds the poison byte
    assert_poison_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      poison_i |=> bank[idx_i] == LANE_POISON);
  end
endmodule

// File: rtl/psram_model.sv
module psram_model
  import psram_pkg::*;
#(
  parameter int                ADDR_W  = 20,
  parameter int                DEPTH_W = 6,
  parameter int                CLK_MHZ = 200,
  parameter int                WAIT_US = 200,
  parameter logic [DATA_W-1:0] POISON  = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  dout_en
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int CNT_W    = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  logic               pwr_ready;
  logic               pwr_poison;
  logic               chip_sel;
  lane_t              wr_lanes;
  lane_t              rd_lanes;
  logic [DEPTH_W-1:0] word_idx;
  logic               unused_addr_hi;

  assign word_idx       = addr[DEPTH_W-1:0];
  assign unused_addr_hi = ^addr[ADDR_W-1:DEPTH_W];

  psram_pwr_fsm #(
    .WAIT_CYC (WAIT_CYC),
    .CNT_W    (CNT_W)
  ) pwr_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cs2_i    (cs2),
    .sel_i    (chip_sel),
    .ready_o  (pwr_ready),
    .poison_o (pwr_poison)
  );

  psram_mode_dec dec_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ready_i    (pwr_ready),
    .cs1_n_i    (cs1_n),
    .cs2_i      (cs2),
    .we_n_i     (we_n),
    .oe_n_i     (oe_n),
    .lane_n_i   ({ub_n, lb_n}),
    .sel_o      (chip_sel),
    .wr_lanes_o (wr_lanes),
    .rd_lanes_o (rd_lanes)
  );

  psram_array #(
    .DEPTH_W (DEPTH_W),
    .POISON  (POISON)
  ) array_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .poison_i   (pwr_poison),
    .wr_lanes_i (wr_lanes),
    .rd_lanes_i (rd_lanes),
    .idx_i      (word_idx),
    .din_i      (din),
    .dout_o     (dout),
    .dout_en_o  (dout_en)
  );

  // R1 and R8: no lane is driven after an edge taken while not ready
  assert_quiet_when_waking_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    !pwr_ready |=> dout_en == '0);

  // R6: an edge with write enable low never leads to driven lanes
  assert_no_drive_on_write_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    !we_n |=> dout_en == '0);

  // R5: deselection leaves both lanes undriven
  assert_deselect_quiet_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    cs1_n || (lb_n && ub_n) |=> dout_en == '0);

  // R4: a lane that is not driven carries zero
  assert_idle_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dout_en[0] || dout[7:0] == '0) && (dout_en[1] || dout[15:8] == '0));
endmodule

// File: tb/psram_model_tb.sv
module psram_model_tb_top;
  localparam int DEPTH_W = 6;
  localparam int DEPTH   = 1 << DEPTH_W;
  localparam int CLK_MHZ = 1;
  localparam int WAIT_US = 20;
  localparam int WAIT_N  = CLK_MHZ * WAIT_US;
  localparam logic [15:0] POISON = 16'hDEAD;

  logic        clk;
  logic        rst_n;
  logic        cs1_n, cs2, we_n, oe_n, lb_n, ub_n;
  logic [19:0] addr;
  logic [15:0] din;
  logic [15:0] dout;
  logic [1:0]  dout_en;

  int    vectors;
  int    miscompares;
  string cur_req;

  logic [15:0] m_mem [DEPTH];
  int          m_sync;
  int          m_wait;
  bit          m_dpd;
  bit          m_ovl;
  logic [15:0] exp_do;
  logic [1:0]  exp_en;

  psram_model #(
    .ADDR_W  (20),
    .DEPTH_W (DEPTH_W),
    .CLK_MHZ (CLK_MHZ),
    .WAIT_US (WAIT_US),
    .POISON  (POISON)
  ) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs1_n   (cs1_n),
    .cs2     (cs2),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .lb_n    (lb_n),
    .ub_n    (ub_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_en (dout_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic model_edge();
    bit ovl;
    int idx;
    ovl    = !cs1_n && !we_n && (!lb_n || !ub_n);
    idx    = int'(addr[DEPTH_W-1:0]);
    exp_en = 2'b00;
    exp_do = 16'h0000;
    if (!rst_n) begin
      m_sync = 2;
      m_wait = WAIT_N;
      m_dpd  = 1'b0;
      m_ovl  = 1'b0;
      return;
    end
    if (m_sync > 0) begin
      m_sync--;
      m_ovl = 1'b0;
      return;
    end
    if (!cs2) begin
      m_dpd = 1'b1;
      for (int w = 0; w < DEPTH; w++) m_mem[w] = POISON;
    end else if (m_dpd) begin
      m_dpd  = 1'b0;
      m_wait = WAIT_N;
    end else if (m_wait > 0) begin
      m_wait--;
    end else begin
      if (ovl && !m_ovl) begin
        if (!lb_n) m_mem[idx][7:0]  = din[7:0];
        if (!ub_n) m_mem[idx][15:8] = din[15:8];
      end
      if (!cs1_n && we_n && !oe_n) begin
        if (!lb_n) begin exp_en[0] = 1'b1; exp_do[7:0]  = m_mem[idx][7:0];  end
        if (!ub_n) begin exp_en[1] = 1'b1; exp_do[15:8] = m_mem[idx][15:8]; end
      end
    end
    m_ovl = ovl;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    vectors++;
    if (dout_en !== exp_en || dout !== exp_do) begin
      miscompares++;
      $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h",
               cur_req, dout_en, dout, exp_en, exp_do);
    end
    @(negedge clk);
  endtask

  task automatic drive_idle();
    cs1_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    lb_n  = 1'b1; ub_n = 1'b1; cs2  = 1'b1;
  endtask

  task automatic do_write(input logic [19:0] a, input logic [15:0] d,
                          input logic l, input logic u, input logic oe);
    cs1_n = 1'b0; we_n = 1'b0; oe_n = oe; lb_n = l; ub_n = u;
    addr = a; din = d;
    step();
    drive_idle();
    step();
  endtask

  task automatic do_read(input logic [19:0] a, input logic l, input logic u);
    cs1_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; lb_n = l; ub_n = u; addr = a;
    step();
    drive_idle();
    step();
  endtask

  initial begin
    vectors = 0; miscompares = 0;
    drive_idle(); addr = '0; din = '0; rst_n = 1'b0;
    m_sync = 2; m_wait = WAIT_N; m_dpd = 1'b0; m_ovl = 1'b0;

    // R1: reset state, then reads and writes during the power-up wait
    cur_req = "R1";
    step(); step();
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) do_read(20'(i), 1'b0, 1'b0);
    do_write(20'd4, 16'h1111, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++) step();

    // R2: fill every word with full-width writes
    cur_req = "R2";
    for (int i = 0; i < DEPTH; i++)
      do_write(20'(i), 16'(i * 257) ^ 16'h5A3C, 1'b0, 1'b0, 1'b1);

    // R4: full, lower-only and upper-only reads
    cur_req = "R4";
    do_read(20'd5, 1'b0, 1'b0);
    do_read(20'd6, 1'b0, 1'b1);
    do_read(20'd7, 1'b1, 1'b0);
    do_read(20'd63, 1'b0, 1'b0);

    // R2: single-lane writes keep the other byte
    cur_req = "R2";
    do_write(20'd7, 16'hFFFF, 1'b0, 1'b1, 1'b1);
    do_read(20'd7, 1'b0, 1'b0);
    do_write(20'd8, 16'h0000, 1'b1, 1'b0, 1'b1);
    do_read(20'd8, 1'b0, 1'b0);

    // R5: both lane enables high, no write, no drive
    cur_req = "R5";
    do_write(20'd9, 16'h1234, 1'b1, 1'b1, 1'b1);
    do_read(20'd9, 1'b1, 1'b1);
    do_read(20'd9, 1'b0, 1'b0);
    cs1_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0; addr = 20'd9;
    step();
    cs1_n = 1'b0; oe_n = 1'b1;
    step();
    drive_idle(); step();

    // R3: overlap held over three edges with changing data and address
    cur_req = "R3";
    cs1_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0; addr = 20'd10; din = 16'h1111;
    step();
    din = 16'h2222; step();
    addr = 20'd11; din = 16'h3333; step();
    drive_idle(); step();
    do_read(20'd10, 1'b0, 1'b0);
    do_read(20'd11, 1'b0, 1'b0);

    // R6: write with output enable low, and write enable falling after a read
    cur_req = "R6";
    do_write(20'd12, 16'hC0DE, 1'b0, 1'b0, 1'b0);
    cs1_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0;
    addr = 20'd12; din = 16'hBEEF;
    step();
    we_n = 1'b0; step();
    drive_idle(); step();
    do_read(20'd12, 1'b0, 1'b0);

    // R9: upper address bits do not select a different word
    cur_req = "R9";
    do_write(20'hABC4D, 16'h600D, 1'b0, 1'b0, 1'b1);
    do_read(20'h0000D, 1'b0, 1'b0);
    do_read(20'hFFFCD, 1'b0, 1'b0);

    // R7: deep power down ignores accesses and poisons the array
    cur_req = "R7";
    cs2 = 1'b0; cs1_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
    addr = 20'd3; din = 16'h4444;
    step(); step(); step();
    we_n = 1'b1; oe_n = 1'b0; step(); step();

    // R8: exit edge and a full wait with accesses ignored
    cur_req = "R8";
    cs2 = 1'b1; step();
    drive_idle(); step();
    do_write(20'd2, 16'h7777, 1'b0, 1'b0, 1'b1);
    do_read(20'd2, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step();

    cur_req = "R7";
    do_read(20'd2, 1'b0, 1'b0);
    do_read(20'd40, 1'b0, 1'b0);
    do_read(20'd3, 1'b1, 1'b0);

    cur_req = "R8";
    do_write(20'd2, 16'h2468, 1'b0, 1'b0, 1'b1);
    do_read(20'd2, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(5 * 200000);
    miscompares++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule